// File: doc/BRIEF.md
# Page-Mode Parallel ROM Reader

This block is a synchronous master for an asynchronous parallel read-only memory that has a page-read feature. A host asks for a burst of consecutive items with a one-cycle request. The request carries a start address, a length and a mode flag. The controller then selects the memory, drives its address bus and returns the items one at a time on a valid/data stream. A done pulse marks the last item.

The memory is read either 16 bits at a time (word mode) or 8 bits at a time (byte mode). In both modes the address is a byte address on the memory bus. Its low four bits pick a location inside a 16-byte page and the bits above them pick the page. For the first item of a burst, and for any item that moves into a new page, the controller waits the full random-access time before it samples. For an item inside the page it is already reading, it waits only the shorter in-page time. All timing limits are given in nanoseconds as parameters and are turned into clock counts by rounding up against a clock-period parameter.

Top module: `prom_page_reader`

## Requirements
- R1: Out of reset and whenever the block is idle, chip enable and output enable are high (inactive), busy is low and item_valid is low.
- R2: The first item of a burst is sampled exactly max(ceil(T_RAND/Tclk), ceil(T_OE/Tclk)) cycles after the request is taken. item_valid rises that many cycles plus one after the request edge.
- R3: A later item whose address bits 23..4 match those of the item before it is sampled ceil(T_PAGE/Tclk) cycles after the previous one.
- R4: A later item whose address bits 23..4 differ from those of the previous item is sampled ceil(T_RAND/Tclk) cycles after the previous one.
- R5: In word mode (byte_mode_i = 0, rom_byte_n_o = 1), address bit 0 on the bus is always 0. The address steps by 2 per item, and the data is the full 16-bit bus.
- R6: In byte mode (byte_mode_i = 1, rom_byte_n_o = 0), the address steps by 1 per item. Only bus bits 7..0 are returned, and bits 15..8 of item_data are 0.
- R7: A burst returns exactly len_i + 1 items. done is high together with item_valid for the last item and for no other item.
- R8: After the last item, both enables go high at once. Chip enable then stays high for at least ceil(T_HZ/Tclk) cycles before the next selection.
- R9: A request made while busy is high is ignored. It starts no burst and does not change the running one.
- R10: While an item is awaited, the bus address stays unchanged. It changes only on the edge where the item is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a burst (taken when busy_o is low) |
| addr_i | input | ADDR_W | Start byte address |
| len_i | input | LEN_W | Item count minus one |
| byte_mode_i | input | 1 | 1 = 8-bit items, 0 = 16-bit items |
| busy_o | output | 1 | Burst or recovery in progress |
| item_valid_o | output | 1 | item_data_o holds a returned item |
| item_data_o | output | DATA_W | Returned item |
| done_o | output | 1 | Last item of the burst |
| rom_addr_o | output | ADDR_W | Memory address bus |
| rom_ce_n_o | output | 1 | Memory chip enable, active low |
| rom_oe_n_o | output | 1 | Memory output enable, active low |
| rom_byte_n_o | output | 1 | Memory width select, low = byte mode |
| rom_data_i | input | DATA_W | Memory data bus |

## Verification
The bench uses the default timing parameters (120 ns random, 25 ns page, 30 ns output enable, 20 ns float) with an 8 ns clock. These give waits of 15, 4, 4 and 3 cycles, so the first-item wait comes from the random-access limit and the page and output-enable counts are the same. The memory model works in nanoseconds, not cycles, and returns a poison value if it is sampled early. Any shortened count therefore shows up as wrong data, and any lengthened count shows up as a wrong arrival cycle. The start addresses put page crossings in the middle of word and byte bursts, at the top of the address space and on an odd word address.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;

  // Round a time in ns up to whole clock cycles; never below one cycle.
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned clk_ps);
    int unsigned c;
    c = (t_ns * 1000 + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_WAIT  = 2'd1,
    RD_RECOV = 2'd2
  } rd_state_t;

endpackage

// File: rtl/prom_wait_timer.sv
module prom_wait_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  // Last cycle of the wait: the owner acts on the coming edge.
  assign expire_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/prom_page_cmp.sv
module prom_page_cmp #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned OFFS_W = 4
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] nxt_i,
  output logic              hit_o
);
  assign hit_o = (cur_i[ADDR_W-1:OFFS_W] == nxt_i[ADDR_W-1:OFFS_W]);
endmodule

// File: rtl/prom_lane_fmt.sv
module prom_lane_fmt #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              byte_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] item_o
);
  localparam int unsigned LANE_W = 8;

  generate
    if (DATA_W > LANE_W) begin : g_wide
      assign item_o = byte_i ? {{(DATA_W-LANE_W){1'b0}}, bus_i[LANE_W-1:0]} : bus_i;
    end else begin : g_narrow
      assign item_o = bus_i;
    end
  endgenerate
endmodule

// File: rtl/prom_page_reader.sv
module prom_page_reader
  import prom_rd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned LEN_W     = 8,
  parameter int unsigned OFFS_W    = 4,
  parameter int unsigned CLK_PS    = 8000,
  parameter int unsigned T_RAND_NS = 120,
  parameter int unsigned T_PAGE_NS = 25,
  parameter int unsigned T_OE_NS   = 30,
  parameter int unsigned T_HZ_NS   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              byte_mode_i,
  output logic              busy_o,
  output logic              item_valid_o,
  output logic [DATA_W-1:0] item_data_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic              rom_ce_n_o,
  output logic              rom_oe_n_o,
  output logic              rom_byte_n_o,
  input  logic [DATA_W-1:0] rom_data_i
);
  localparam int unsigned N_RAND  = ns_to_cyc(T_RAND_NS, CLK_PS);
  localparam int unsigned N_PAGE  = ns_to_cyc(T_PAGE_NS, CLK_PS);
  localparam int unsigned N_OE    = ns_to_cyc(T_OE_NS, CLK_PS);
  localparam int unsigned N_HZ    = ns_to_cyc(T_HZ_NS, CLK_PS);
  localparam int unsigned N_FIRST = max2(N_RAND, N_OE);
  localparam int unsigned N_MAX   = max2(max2(N_FIRST, N_HZ), N_PAGE);
  localparam int unsigned CNT_W   = $clog2(N_MAX + 1);

  rd_state_t          st_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [LEN_W-1:0]   left_q;
  logic               byte_q;
  logic               ce_n_q, oe_n_q;
  logic               valid_q, done_q;
  logic [DATA_W-1:0]  data_q;

  // Named internal events
  logic               take_req;   // host request accepted this cycle
  logic               wait_done;  // timer reaches its end
  logic               cap_ev;     // an item is captured on the coming edge
  logic               last_item;  // the captured item ends the burst
  logic               page_hit;   // next address stays in the current page
  logic               tmr_load;
  logic [CNT_W-1:0]   tmr_val;
  logic [ADDR_W-1:0]  nxt_addr;
  logic [ADDR_W-1:0]  start_addr;
  logic [DATA_W-1:0]  fmt_data;

  assign take_req   = (st_q == RD_IDLE) && req_i;
  assign cap_ev     = (st_q == RD_WAIT) && wait_done;
  assign last_item  = (left_q == '0);
  assign nxt_addr   = addr_q + (byte_q ? ADDR_W'(1) : ADDR_W'(2));
  assign start_addr = byte_mode_i ? addr_i : {addr_i[ADDR_W-1:1], 1'b0};

  prom_wait_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (tmr_load),
    .val_i    (tmr_val),
    .expire_o (wait_done)
  );

  prom_page_cmp #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_pg (
    .cur_i (addr_q),
    .nxt_i (nxt_addr),
    .hit_o (page_hit)
  );

  prom_lane_fmt #(.DATA_W(DATA_W)) u_fmt (
    .byte_i (byte_q),
    .bus_i  (rom_data_i),
    .item_o (fmt_data)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (take_req) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(N_FIRST);
    end else if (cap_ev) begin
      tmr_load = 1'b1;
      if (last_item)     tmr_val = CNT_W'(N_HZ);
      else if (page_hit) tmr_val = CNT_W'(N_PAGE);
      else               tmr_val = CNT_W'(N_RAND);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RD_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      byte_q  <= 1'b0;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      case (st_q)
        RD_IDLE: begin
          if (req_i) begin
            addr_q <= start_addr;
            left_q <= len_i;
            byte_q <= byte_mode_i;
            ce_n_q <= 1'b0;
            oe_n_q <= 1'b0;
            st_q   <= RD_WAIT;
          end
        end
        RD_WAIT: begin
          if (wait_done) begin
            valid_q <= 1'b1;
            data_q  <= fmt_data;
            if (last_item) begin
              done_q <= 1'b1;
              ce_n_q <= 1'b1;
              oe_n_q <= 1'b1;
              st_q   <= RD_RECOV;
            end else begin
              left_q <= left_q - 1'b1;
              addr_q <= nxt_addr;
            end
          end
        end
        RD_RECOV: begin
          if (wait_done) st_q <= RD_IDLE;
        end
        default: st_q <= RD_IDLE;
      endcase
    end
  end

  assign busy_o       = (st_q != RD_IDLE);
  assign item_valid_o = valid_q;
  assign item_data_o  = data_q;
  assign done_o       = done_q;
  assign rom_addr_o   = addr_q;
  assign rom_ce_n_o   = ce_n_q;
  assign rom_oe_n_o   = oe_n_q;
  assign rom_byte_n_o = ~byte_q;

  // Cycles chip enable has been high, saturating; feeds the float-gap check.
  logic [7:0] hz_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hz_run_q <= 8'hFF;
    else if (!rom_ce_n_o)    hz_run_q <= '0;
    else if (hz_run_q != 8'hFF) hz_run_q <= hz_run_q + 1'b1;
  end

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (rom_ce_n_o && rom_oe_n_o && !item_valid_o)); // R1

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_ce_n_o && !cap_ev) |=> $stable(rom_addr_o)); // R10

  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_ce_n_o && rom_byte_n_o) |-> !rom_addr_o[0]); // R5

  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (item_valid_o && !rom_byte_n_o) |-> (item_data_o[DATA_W-1:8] == '0)); // R6

  AST_DONE_WITH_ITEM: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (item_valid_o && rom_ce_n_o && rom_oe_n_o)); // R7

  AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_ce_n_o) |-> (hz_run_q >= 8'(N_HZ))); // R8

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(rom_byte_n_o)); // R9

endmodule

// File: tb/sim_prom_page_reader.sv
module sim_prom_page_reader;
  localparam int CLK_NS = 8;
  localparam int T_RAND = 120;
  localparam int T_PAGE = 25;
  localparam int T_OE   = 30;
  localparam int T_HZ   = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [23:0] addr = '0;
  logic [7:0]  len = '0;
  logic        bmode = 1'b0;
  logic        busy, item_valid, done, ce_n, oe_n, byte_n;
  logic [15:0] item_data;
  logic [23:0] rom_addr;
  logic [15:0] rom_data = 16'hBAD0;

  int total = 0;
  int bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  prom_page_reader u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr), .len_i(len),
    .byte_mode_i(bmode), .busy_o(busy), .item_valid_o(item_valid),
    .item_data_o(item_data), .done_o(done), .rom_addr_o(rom_addr),
    .rom_ce_n_o(ce_n), .rom_oe_n_o(oe_n), .rom_byte_n_o(byte_n),
    .rom_data_i(rom_data)
  );

  function automatic int cyc_of(input int t);
    int n = 0;
    while (n * CLK_NS < t) n++;
    return (n == 0) ? 1 : n;
  endfunction

  function automatic logic [15:0] pat(input logic [23:0] x);
    return (x[15:0] * 16'h9E37) ^ {x[23:16], x[7:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory model, timed in ns; poison data if sampled too early.
  logic [23:0] m_addr = '0;
  int  m_age = 0, m_need = T_RAND, oe_age = 0, hi_run = 1000;
  int  vcount = 0, ce_falls = 0, align_bad = 0, hz_bad = 0;
  bit  m_sel = 0, oe_prev = 0;
  always @(negedge clk) begin
    if (ce_n) begin
      m_sel = 0; m_age = 0; hi_run++;
    end else begin
      if (hi_run > 0) begin
        ce_falls++;
        if (hi_run * CLK_NS < T_HZ) hz_bad++;
      end
      hi_run = 0;
      if (!m_sel || rom_addr != m_addr) begin
        m_need = (m_sel && (rom_addr >> 4) == (m_addr >> 4)) ? T_PAGE : T_RAND;
        m_age = 0; m_addr = rom_addr;
      end else m_age++;
      m_sel = 1;
      if (byte_n && rom_addr[0]) align_bad++;
    end
    if (oe_n || !oe_prev) oe_age = 0; else oe_age++;
    oe_prev = !oe_n;
    if (!ce_n && !oe_n && (m_age + 1) * CLK_NS >= m_need && (oe_age + 1) * CLK_NS >= T_OE)
      rom_data = byte_n ? pat(m_addr >> 1) : {8'hA5, pat(m_addr)[7:0]};
    else
      rom_data = 16'hBAD0;
    if (item_valid) vcount++;
  end

  // bm(1) len(8) addr(24)
  localparam logic [32:0] VEC [6] = '{
    {1'b0, 8'd3, 24'h000020},
    {1'b0, 8'd3, 24'h00003C},
    {1'b1, 8'd5, 24'h123456},
    {1'b1, 8'd3, 24'h00FFFE},
    {1'b0, 8'd0, 24'h000011},
    {1'b0, 8'd3, 24'hFFFFF8}
  };

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic run_burst(input logic [23:0] a0, input logic [7:0] ln, input logic bm);
    logic [23:0] a, prev;
    int exp_cyc, cyc, idx, np, nr;
    np = cyc_of(T_PAGE); nr = cyc_of(T_RAND);
    a = bm ? a0 : {a0[23:1], 1'b0};
    wait_idle();
    req = 1; addr = a0; len = ln; bmode = bm;
    @(posedge clk); cyc = 1;
    @(negedge clk); req = 0;
    exp_cyc = ((nr > cyc_of(T_OE)) ? nr : cyc_of(T_OE)) + 1;
    idx = 0;
    while (idx <= int'(ln) && cyc < 600) begin
      if (item_valid) begin
        if (idx == 0) chk(cyc == exp_cyc, "R2 first item cycle", cyc, exp_cyc);
        else if ((a >> 4) == (prev >> 4)) chk(cyc == exp_cyc, "R3 in-page cycle", cyc, exp_cyc);
        else chk(cyc == exp_cyc, "R4 page-cross cycle", cyc, exp_cyc);
        if (bm) chk(item_data == {8'h00, pat(a)[7:0]}, "R6 byte data", item_data, {8'h00, pat(a)[7:0]});
        else    chk(item_data == pat(a >> 1), "R5 word data", item_data, pat(a >> 1));
        chk(done == (idx == int'(ln)), "R7 done position", done, idx == int'(ln));
        prev = a;
        a = a + (bm ? 24'd1 : 24'd2);
        exp_cyc = cyc + (((a >> 4) == (prev >> 4)) ? np : nr);
        idx++;
      end
      @(posedge clk); cyc++;
      @(negedge clk);
    end
    chk(idx == int'(ln) + 1, "R7 item count", idx, int'(ln) + 1);
    chk(ce_n && oe_n, "R8 deselect after done", {ce_n, oe_n}, 2'b11);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v0, f0;
    repeat (3) @(negedge clk);
    chk(ce_n && oe_n && !busy && !item_valid, "R1 in reset", {ce_n, oe_n, busy, item_valid}, 4'b1100);
    rst_n = 1;
    @(negedge clk);
    chk(ce_n && oe_n && !busy && !item_valid, "R1 after reset", {ce_n, oe_n, busy, item_valid}, 4'b1100);

    for (int i = 0; i < 6; i++) run_burst(VEC[i][23:0], VEC[i][31:24], VEC[i][32]);

    // R9: second request while busy is dropped
    wait_idle();
    v0 = vcount; f0 = ce_falls;
    req = 1; addr = 24'h000400; len = 8'd2; bmode = 0;
    @(negedge clk); req = 0;
    repeat (3) @(negedge clk);
    req = 1; addr = 24'h000800; len = 8'd7; bmode = 1;
    @(negedge clk); req = 0;
    wait_idle();
    repeat (30) @(negedge clk);
    chk(vcount - v0 == 3, "R9 items with busy request", vcount - v0, 3);
    chk(ce_falls - f0 == 1, "R9 selections with busy request", ce_falls - f0, 1);
    chk(!busy && ce_n && oe_n, "R1 idle after burst", {busy, ce_n, oe_n}, 3'b011);

    // R1: reset in the middle of a burst deselects at once
    req = 1; addr = 24'h000100; len = 8'd9; bmode = 0;
    @(negedge clk); req = 0;
    repeat (5) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(ce_n && oe_n && !busy, "R1 reset mid-burst", {ce_n, oe_n, busy}, 3'b110);
    rst_n = 1;
    repeat (4) @(negedge clk);
    run_burst(24'h0000FC, 8'd2, 1'b0);

    chk(align_bad == 0, "R5 word address bit0", align_bad, 0);
    chk(hz_bad == 0, "R8 float gap", hz_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule